// File: doc/BRIEF.md
# Round-Robin Arbiter with Held Priority

This block shares one resource among `NUM_REQ` requesters. In every cycle it looks at the request vector and returns a one-hot grant. The winner is the first requesting line found when the search starts at a rotating priority pointer and wraps past the top line. The search is not a sequential scan. It is a single wide subtraction on a doubled copy of the request vector. The borrow ripples up through the zero bits and stops at the first set bit, and the two halves of the result are folded back together.

The pointer moves only on a cycle in which the advance input is high and at least one line is requesting. It then takes the value of the current winner rotated up by one position. While the resource is busy, the user holds the advance input low. The pointer then stays frozen, so with unchanged requests the same requester keeps the grant until the resource can take it. The grant is combinational from the requests and the registered pointer. The pointer register is the only state.

Top module: `rr_hold_arbiter`

## Requirements
- R1: `gnt` never has more than one bit set.
- R2: A `gnt` bit is only set on a line whose `req_vec` bit is set, and `gnt` is nonzero whenever `req_vec` is nonzero.
- R3: The granted line is the first requesting index found walking upward from the pointer position (pointer bit i selects index i) and wrapping from index NUM_REQ-1 to index 0.
- R4: On a clock edge with `adv` high and `req_vec` nonzero, the pointer becomes the granted one-hot vector rotated left by one, with bit NUM_REQ-1 moving to bit 0.
- R5: On a clock edge with `adv` low, the pointer does not change, so unchanged requests keep the same grant.
- R6: When `req_vec` is zero, `gnt` is zero and the pointer does not change, even with `adv` high.
- R7: Reset, asynchronous and active low, sets the pointer to bit 0. The first grant after reset therefore goes to the lowest-numbered requesting line.
- R8: A line that requests without a break is granted within NUM_REQ consecutive advancing cycles.
- R9: `NUM_REQ` below 2 is refused at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vec | input | NUM_REQ | One bit per requester |
| adv | input | 1 | Lets the priority pointer advance at the next edge |
| gnt | output | NUM_REQ | One-hot grant, zero when no request |

## Verification
The pointer is the only state. A wrong pointer value shows at `gnt` in the very next cycle in which more than one line requests, because the winner moves to a different line. A pointer that fails to hold while `adv` is low shows as a grant that changes under constant requests. A pointer that fails to advance shows as the same line winning again, and that breaks the NUM_REQ bound on how long a waiting line can be passed over. A fault in the picker shows at once, as a multi-hot grant or a grant on an idle line.

// File: rtl/rra_pkg.sv
package rra_pkg;
   // What the pointer register does at the next edge
   typedef enum logic {
      PTR_KEEP = 1'b0,
      PTR_LOAD = 1'b1
   } ptr_op_e;
endpackage

// File: rtl/rra_rotl.sv
module rra_rotl #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   if (WIDTH < 2) begin : g_bad_width
      $error("rra_rotl: WIDTH must be at least 2");
   end

   // Each output bit takes the bit one position below it; bit 0 takes the top bit
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (i == 0) begin : g_wrap
         assign dout[i] = din[WIDTH-1];
      end else begin : g_shift
         assign dout[i] = din[i-1];
      end
   end
endmodule

// File: rtl/rra_wrap_pick.sv
module rra_wrap_pick #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] req,
   input  logic [WIDTH-1:0] base,
   output logic [WIDTH-1:0] pick
);
   localparam int DW = 2 * WIDTH;

   if (WIDTH < 2) begin : g_bad_width
      $error("rra_wrap_pick: WIDTH must be at least 2");
   end

   logic [DW-1:0] dbl;
   logic [DW-1:0] base_ext;
   logic [DW-1:0] diff;
   logic [DW-1:0] keep;

   assign dbl      = {req, req};
   assign base_ext = {{WIDTH{1'b0}}, base};
   // The borrow runs up through zeros and clears the first set bit at or above base
   assign diff     = dbl - base_ext;
   assign keep     = dbl & ~diff;

   // Fold the upper copy (wrapped hits) onto the lower copy
   for (genvar i = 0; i < WIDTH; i++) begin : g_fold
      assign pick[i] = keep[i] | keep[i+WIDTH];
   end

   // R1 and R2 for any one-hot base: result is one-hot, lies on a request, and is present when any request is
   always_comb begin
      if ($onehot(base)) begin
         a_r1_pick_onehot: assert ($onehot0(pick));
         a_r2_pick_on_req: assert ((pick & ~req) == '0);
         a_r2_pick_present: assert ((req == '0) || (pick != '0));
      end
   end
endmodule

// File: rtl/rra_ptr_reg.sv
module rra_ptr_reg
   import rra_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ptr_op_e          op,
   input  logic [WIDTH-1:0] nxt,
   output logic [WIDTH-1:0] ptr
);
   localparam logic [WIDTH-1:0] PTR_RESET = {{(WIDTH-1){1'b0}}, 1'b1};

   if (WIDTH < 2) begin : g_bad_width
      $error("rra_ptr_reg: WIDTH must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= PTR_RESET;
      end else if (op == PTR_LOAD) begin
         ptr <= nxt;
      end
   end

   // R5/R6: no load request, no change
   a_r5_keep_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (op == PTR_KEEP) |=> $stable(ptr));
   // The pointer stays one-hot
   a_r7_ptr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(ptr));
endmodule

// File: rtl/rr_hold_arbiter.sv
module rr_hold_arbiter
   import rra_pkg::*;
#(
   parameter int NUM_REQ = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_REQ-1:0] req_vec,
   input  logic               adv,
   output logic [NUM_REQ-1:0] gnt
);
   // R9: refuse degenerate sizes
   if (NUM_REQ < 2) begin : g_bad_num_req
      $error("rr_hold_arbiter: NUM_REQ must be at least 2");
   end

   logic [NUM_REQ-1:0] ptr;
   logic [NUM_REQ-1:0] ptr_nxt;
   ptr_op_e            ptr_op;

   rra_wrap_pick #(.WIDTH(NUM_REQ)) u_pick (
      .req  (req_vec),
      .base (ptr),
      .pick (gnt)
   );

   rra_rotl #(.WIDTH(NUM_REQ)) u_rot (
      .din  (gnt),
      .dout (ptr_nxt)
   );

   // Advance only when asked and when there is a winner to step past
   assign ptr_op = (adv && (req_vec != '0)) ? PTR_LOAD : PTR_KEEP;

   rra_ptr_reg #(.WIDTH(NUM_REQ)) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (ptr_op),
      .nxt   (ptr_nxt),
      .ptr   (ptr)
   );

   a_r1_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
   a_r2_grant_on_request: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~req_vec) == '0);
   a_r4_pointer_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && (req_vec != '0)) |=>
         (ptr == {$past(gnt[NUM_REQ-2:0]), $past(gnt[NUM_REQ-1])}));
   a_r5_hold_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv) ##1 $stable(req_vec) |-> $stable(gnt));
   a_r6_idle_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vec == '0) |-> (gnt == '0));
   a_r6_idle_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vec == '0) |=> $stable(ptr));
endmodule

// File: tb/sim_rr_hold_arbiter.sv
module sim_rr_hold_arbiter;
   localparam int N      = 4;
   localparam int CLK_NS = 10;
   localparam int NVEC   = 15;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] req_vec = '0;
   logic         adv = 1'b0;
   logic [N-1:0] gnt;

   int checks = 0;
   int errors = 0;

   always #(CLK_NS/2) clk = ~clk;

   rr_hold_arbiter #(.NUM_REQ(N)) u0 (
      .clk(clk), .rst_n(rst_n), .req_vec(req_vec), .adv(adv), .gnt(gnt)
   );

   // {req, adv, expected grant}, walked from reset (pointer at bit 0)
   typedef struct packed {
      logic [N-1:0] req;
      logic         adv;
      logic [N-1:0] exp;
   } vec_t;

   localparam vec_t VEC [NVEC] = '{
      '{4'b1010, 1'b1, 4'b0010},  // R7 first grant, R4 ptr->0100
      '{4'b1010, 1'b1, 4'b1000},  // R3 search upward, R4 wrap ptr->0001
      '{4'b1010, 1'b0, 4'b0010},  // R5 hold
      '{4'b1010, 1'b0, 4'b0010},  // R5 hold again
      '{4'b0000, 1'b1, 4'b0000},  // R6 idle, ptr stays 0001
      '{4'b1001, 1'b1, 4'b0001},  // R6 ptr unchanged, ptr->0010
      '{4'b1001, 1'b1, 4'b1000},  // R3 skip idle lines
      '{4'b1111, 1'b1, 4'b0001},
      '{4'b1111, 1'b1, 4'b0010},
      '{4'b1111, 1'b1, 4'b0100},
      '{4'b1111, 1'b1, 4'b1000},  // R4 top winner, ptr->0001
      '{4'b0100, 1'b0, 4'b0100},  // R2 single request
      '{4'b0001, 1'b1, 4'b0001},  // ptr->0010
      '{4'b0001, 1'b1, 4'b0001},  // R3 wrap past top
      '{4'b0110, 1'b1, 4'b0010}   // R5 ptr stayed 0010 after sole-line repeat
   };

   task automatic check(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: gnt=%b expected=%b", tag, act, exp);
      end
   endtask

   // Drive at negedge, sample a quarter period later, well before the next edge
   task automatic step(input logic [N-1:0] r, input logic a, input logic [N-1:0] exp, input string tag);
      @(negedge clk);
      req_vec = r;
      adv = a;
      #(CLK_NS/4);
      check(gnt, exp, tag);
   endtask

   // Reference winner by plain scan from pointer index
   function automatic logic [N-1:0] ref_pick(input logic [N-1:0] r, input logic [N-1:0] p);
      int start = 0;
      logic [N-1:0] g = '0;
      for (int i = 0; i < N; i++) if (p[i]) start = i;
      for (int k = 0; k < N; k++) begin
         int idx = (start + k) % N;
         if (g == '0 && r[idx]) g[idx] = 1'b1;
      end
      return g;
   endfunction

   initial begin : watchdog
      #(CLK_NS * 20000);
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      logic [N-1:0] mptr;
      logic [N-1:0] eg;
      logic [15:0]  lfsr;
      int           wait_cnt [N];

      // R7: reset state seen through the grant
      #(CLK_NS * 2);
      req_vec = 4'b1111;
      #1;
      check(gnt, 4'b0001, "R7 grant during reset");
      @(negedge clk);
      rst_n = 1'b1;

      for (int v = 0; v < NVEC; v++) begin
         step(VEC[v].req, VEC[v].adv, VEC[v].exp, $sformatf("R3/R4/R5/R6 vector %0d", v));
      end

      // R7: mid-run reset returns pointer to bit 0 (pointer is now 0100)
      step(4'b1111, 1'b0, 4'b0100, "R5 pointer before reset");
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(gnt, 4'b0001, "R7 grant after async reset");
      @(negedge clk);
      rst_n = 1'b1;
      step(4'b1110, 1'b1, 4'b0010, "R7 lowest requester after reset");

      // R6: idle cycles with advance high leave the pointer (now 0100)
      step(4'b0000, 1'b1, 4'b0000, "R6 idle grant zero");
      step(4'b0000, 1'b1, 4'b0000, "R6 idle grant zero again");
      step(4'b0011, 1'b0, 4'b0001, "R6 pointer unchanged by idle advance");

      // R1/R2/R3/R8: pseudo-random traffic against reference scan and wait bound
      // pointer currently 0100 (after 1110 grant 0010 advanced)
      mptr = 4'b0100;
      lfsr = 16'hACE1;
      for (int i = 0; i < N; i++) wait_cnt[i] = 0;
      for (int c = 0; c < 400; c++) begin
         logic [N-1:0] r;
         logic         a;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         r = lfsr[3:0] | 4'b0001;       // line 0 requests without a break
         if (c >= 200) r = lfsr[3:0] | 4'b1000;
         a = lfsr[7] | lfsr[9];
         eg = ref_pick(r, mptr);
         step(r, a, eg, $sformatf("R3 traffic cycle %0d", c));
         checks++;
         if ($countones(gnt) > 1 || (gnt & ~r) != '0) begin
            errors++;
            $display("FAIL R1/R2 cycle %0d: gnt=%b req=%b expected one-hot subset", c, gnt, r);
         end
         if (a) begin
            for (int i = 0; i < N; i++) begin
               if (!r[i] || eg[i]) wait_cnt[i] = 0;
               else wait_cnt[i]++;
            end
            mptr = {eg[N-2:0], eg[N-1]};
         end
         for (int i = 0; i < N; i++) begin
            if (wait_cnt[i] >= N) begin
               checks++;
               errors++;
               $display("FAIL R8 line %0d: waited %0d advances, expected below %0d", i, wait_cnt[i], N);
               wait_cnt[i] = 0;
            end
         end
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule